// File: doc/BRIEF.md
# Multichannel Audio Sample Holding Buffer

This block holds audio samples between a register-style host port and a multichannel serial audio engine that frames data as I2S, left-justified or TDM. Each channel slot has its own small sample store in each direction. The depth of a slot and the number of active slots come from three configuration fields (format, wiring, channel count), so the total storage stays fixed while its split changes. Slot index `s` means data line `s/2`; bit 0 of the index picks the side (0 = left, 1 = right).

The host reaches samples in one of two ways. The common path visits the active slots in rotation. The dedicated path names one slot directly. When the FIFO mode bit is latched, the common path is routed instead through an 8-entry transmit FIFO and an 8-entry receive FIFO. The engine side is two valid/ready streams, each stepping through the active slots in rotation. On the transmit stream the buffer presents a sample and holds it, unchanged, until the engine takes it. On the receive stream the buffer raises ready only while the target store has room, and it keeps ready high until a transfer happens. Host accesses are single-cycle strobes with no back-pressure: a write that cannot be stored is dropped, and a read that finds nothing returns zero. Both events are recorded in sticky flags.

Top module: `msb_hold_buf`

## Requirements
- R1: With format code 0 or 1 (I2S / left-justified), wiring code 0 gives slot depth 4 with 2 active slots, code 1 gives depth 2 with 4 slots, and code 2 or 3 gives depth 1 with 8 slots.
- R2: With format code 2 or 3 (TDM), channel-count codes 0–1 give depth 4 with 2 slots, codes 2–3 give depth 2 with 4 slots, and codes 4–7 give depth 1 with 8 slots.
- R3: Slots at or above the active count report not-ready. A dedicated write to such a slot is dropped and sets `tx_ovr`. A dedicated read of such a slot returns zero and sets `rx_udr`.
- R4: Common-path writes and reads each use their own slot pointer. The pointer starts at slot 0 after enable, advances by one on every common access, and wraps to 0 after the last active slot.
- R5: A dedicated access reaches only the named slot. A write to a full slot is dropped and sets `tx_ovr`, which stays set until the block is disabled.
- R6: A read from an empty slot (or an empty receive FIFO) returns zero on `h_rx_data` one cycle after the strobe and sets the sticky `rx_udr`. A successful read returns the oldest sample one cycle after the strobe.
- R7: `e_tx_valid` is high when the slot named by `e_tx_slot` holds a sample. While `e_tx_ready` is low, valid, data and slot stay unchanged. Each transfer advances `e_tx_slot` through the active slots in rotation.
- R8: `e_rx_ready` is high when the slot named by `e_rx_slot` has room. Once high, it stays high until a transfer. Each transfer stores the sample and advances `e_rx_slot` in rotation.
- R9: In FIFO mode, common writes and reads go through the 8-entry transmit and receive FIFOs and are kept in order. A common write to a full FIFO is dropped and sets `tx_ovr`. Dedicated accesses have no effect (a dedicated read returns zero without setting `rx_udr`), and all per-slot ready flags read 0.
- R10: In FIFO mode, `txff_rdy` means at least one free entry, `txff_emp` means zero entries, `rxff_rdy` means at least one entry, and `rxff_ful` means eight entries. All four flags read 0 outside FIFO mode.
- R11: The format, wiring, channel-count and FIFO mode inputs are sampled only while `en` is low. Changes while enabled have no effect. Dropping `en` empties every store and clears both sticky flags.
- R12: After reset, with `en` low, every ready, valid and status output is 0 and `h_rx_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable; low clears stores and samples configuration |
| fifo_mode | input | 1 | FIFO mode bit for the common path |
| fmt | input | 2 | Framing format code (0,1 I2S/LJ; 2,3 TDM) |
| wire_cfg | input | 2 | Wiring code (I2S/LJ only) |
| nch_code | input | 3 | Channel-count code (TDM only) |
| h_tx_wr | input | 1 | Host transmit write strobe |
| h_tx_common | input | 1 | 1 = common path, 0 = dedicated slot |
| h_tx_slot | input | SLOT_W | Dedicated transmit slot index |
| h_tx_data | input | SMP_W | Host transmit sample |
| h_rx_rd | input | 1 | Host receive read strobe |
| h_rx_common | input | 1 | 1 = common path, 0 = dedicated slot |
| h_rx_slot | input | SLOT_W | Dedicated receive slot index |
| h_rx_data | output | SMP_W | Read result, registered |
| e_tx_valid | output | 1 | Transmit sample available |
| e_tx_ready | input | 1 | Engine takes transmit sample |
| e_tx_data | output | SMP_W | Transmit sample |
| e_tx_slot | output | SLOT_W | Slot of the presented transmit sample |
| e_rx_valid | input | 1 | Engine offers receive sample |
| e_rx_ready | output | 1 | Receive store has room |
| e_rx_data | input | SMP_W | Receive sample |
| e_rx_slot | output | SLOT_W | Slot the next receive sample fills |
| tx_slot_rdy | output | NSLOT | Per-slot transmit room flags |
| rx_slot_rdy | output | NSLOT | Per-slot receive data flags |
| txff_rdy | output | 1 | Transmit FIFO has room |
| txff_emp | output | 1 | Transmit FIFO empty |
| rxff_rdy | output | 1 | Receive FIFO has data |
| rxff_ful | output | 1 | Receive FIFO full |
| tx_ovr | output | 1 | Sticky dropped-write flag |
| rx_udr | output | 1 | Sticky empty-read flag |

## Verification
The bench builds the block with its defaults: four data lines (eight slots), a maximum slot depth of four and an eight-entry FIFO. With these values every row of the depth decode can be reached, including the 2-, 4- and 8-slot splits. The default depths also let the bench fill a slot and the FIFOs to their limits within a handful of accesses. Pointer wrap, dropped writes, empty reads, inactive slots and the frozen configuration are all exercised at these limits.

// File: rtl/msb_pkg.sv
`timescale 1ns/1ps
package msb_pkg;
  typedef struct packed {
    logic       fifo;
    logic [1:0] fmt;
    logic [1:0] wcfg;
    logic [2:0] nch;
  } cfg_t;

  // log2 of the per-slot depth: 2 -> 4 words, 1 -> 2 words, 0 -> 1 word
  function automatic logic [1:0] depth_log2(cfg_t c);
    logic [1:0] r;
    case (c.fmt)
      2'd0, 2'd1: begin
        case (c.wcfg)
          2'd0:    r = 2'd2;
          2'd1:    r = 2'd1;
          default: r = 2'd0;
        endcase
      end
      default: begin
        case (c.nch)
          3'd0, 3'd1: r = 2'd2;
          3'd2, 3'd3: r = 2'd1;
          default:    r = 2'd0;
        endcase
      end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/msb_cfg.sv
`timescale 1ns/1ps
module msb_cfg #(
  parameter int NSLOT  = 8,
  parameter int MAXD   = 4,
  localparam int SLOT_W = $clog2(NSLOT),
  localparam int LIM_W  = $clog2(MAXD + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  msb_pkg::cfg_t      cfg_in,
  output msb_pkg::cfg_t      cfg_q,
  output logic [LIM_W-1:0]   lim,
  output logic [SLOT_W-1:0]  last,
  output logic [NSLOT-1:0]   act
);
  logic [1:0] dl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cfg_q <= '0;
    else if (!en) cfg_q <= cfg_in;
  end

  always_comb begin
    int n;
    dl  = msb_pkg::depth_log2(cfg_q);
    lim = LIM_W'(1) << dl;
    case (dl)
      2'd2:    n = 2;
      2'd1:    n = 4;
      default: n = 8;
    endcase
    if (n > NSLOT) n = NSLOT;
    last = SLOT_W'(n - 1);
    for (int i = 0; i < NSLOT; i++) act[i] = (i < n);
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> $stable(cfg_q)); // R11
endmodule

// File: rtl/msb_ring.sv
`timescale 1ns/1ps
module msb_ring #(
  parameter int DEPTH = 4,
  parameter int W     = 32,
  localparam int LIM_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [LIM_W-1:0] lim,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic             full,
  output logic             empty
);
  logic [W-1:0]     mem [DEPTH];
  logic [IDX_W-1:0] wp, rp;
  logic [LIM_W-1:0] cnt;

  function automatic logic [IDX_W-1:0] step(logic [IDX_W-1:0] p, logic [LIM_W-1:0] l);
    return (p == IDX_W'(l - LIM_W'(1))) ? '0 : p + IDX_W'(1);
  endfunction

  assign full  = (cnt >= lim);
  assign empty = (cnt == '0);
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push) wp <= step(wp, lim);
      if (pop)  rp <= step(rp, lim);
      cnt <= cnt + LIM_W'(push) - LIM_W'(pop);
    end
  end

  AST_RING_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n || clr)
    push |-> !full); // R5
  AST_RING_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n || clr)
    pop |-> !empty); // R6
  AST_RING_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n || clr)
    1'b1 |=> (cnt <= lim)); // R1
endmodule

// File: rtl/msb_rr_ptr.sv
`timescale 1ns/1ps
module msb_rr_ptr #(
  parameter int N = 8,
  localparam int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  input  logic [SW-1:0] last,
  output logic [SW-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr <= '0;
    else if (clr) ptr <= '0;
    else if (adv) ptr <= (ptr == last) ? '0 : ptr + SW'(1);
  end

  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n || clr)
    1'b1 |=> (ptr <= last)); // R4
endmodule

// File: rtl/msb_hold_buf.sv
`timescale 1ns/1ps
module msb_hold_buf #(
  parameter int NLINES = 4,
  parameter int SMP_W  = 32,
  parameter int MAXD   = 4,
  parameter int FIFO_D = 8,
  localparam int NSLOT  = 2 * NLINES,
  localparam int SLOT_W = $clog2(NSLOT),
  localparam int LIM_W  = $clog2(MAXD + 1),
  localparam int FLIM_W = $clog2(FIFO_D + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              fifo_mode,
  input  logic [1:0]        fmt,
  input  logic [1:0]        wire_cfg,
  input  logic [2:0]        nch_code,
  input  logic              h_tx_wr,
  input  logic              h_tx_common,
  input  logic [SLOT_W-1:0] h_tx_slot,
  input  logic [SMP_W-1:0]  h_tx_data,
  input  logic              h_rx_rd,
  input  logic              h_rx_common,
  input  logic [SLOT_W-1:0] h_rx_slot,
  output logic [SMP_W-1:0]  h_rx_data,
  output logic              e_tx_valid,
  input  logic              e_tx_ready,
  output logic [SMP_W-1:0]  e_tx_data,
  output logic [SLOT_W-1:0] e_tx_slot,
  input  logic              e_rx_valid,
  output logic              e_rx_ready,
  input  logic [SMP_W-1:0]  e_rx_data,
  output logic [SLOT_W-1:0] e_rx_slot,
  output logic [NSLOT-1:0]  tx_slot_rdy,
  output logic [NSLOT-1:0]  rx_slot_rdy,
  output logic              txff_rdy,
  output logic              txff_emp,
  output logic              rxff_rdy,
  output logic              rxff_ful,
  output logic              tx_ovr,
  output logic              rx_udr
);
  msb_pkg::cfg_t cfg_in, cfg_q;
  logic [LIM_W-1:0]  lim;
  logic [SLOT_W-1:0] last;
  logic [NSLOT-1:0]  act;
  logic              clr, fm;

  assign cfg_in = '{fifo: fifo_mode, fmt: fmt, wcfg: wire_cfg, nch: nch_code};
  assign clr    = !en;
  assign fm     = cfg_q.fifo;

  msb_cfg #(.NSLOT(NSLOT), .MAXD(MAXD)) u_cfg (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_in(cfg_in),
    .cfg_q(cfg_q), .lim(lim), .last(last), .act(act));

  // ---------------- slot pointers ----------------
  logic [SLOT_W-1:0] hptr_tx, hptr_rx, eptr_tx, eptr_rx;
  logic adv_htx, adv_hrx, tx_hs, rx_hs;

  msb_rr_ptr #(.N(NSLOT)) u_ptr_htx (.clk(clk), .rst_n(rst_n), .clr(clr),
    .adv(adv_htx), .last(last), .ptr(hptr_tx));
  msb_rr_ptr #(.N(NSLOT)) u_ptr_hrx (.clk(clk), .rst_n(rst_n), .clr(clr),
    .adv(adv_hrx), .last(last), .ptr(hptr_rx));
  msb_rr_ptr #(.N(NSLOT)) u_ptr_etx (.clk(clk), .rst_n(rst_n), .clr(clr),
    .adv(tx_hs), .last(last), .ptr(eptr_tx));
  msb_rr_ptr #(.N(NSLOT)) u_ptr_erx (.clk(clk), .rst_n(rst_n), .clr(clr),
    .adv(rx_hs), .last(last), .ptr(eptr_rx));

  // ---------------- per-slot stores ----------------
  logic [NSLOT-1:0] st_push, st_pop, st_full, st_empty;
  logic [NSLOT-1:0] sr_push, sr_pop, sr_full, sr_empty;
  logic [SMP_W-1:0] st_dout [NSLOT];
  logic [SMP_W-1:0] sr_dout [NSLOT];

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    msb_ring #(.DEPTH(MAXD), .W(SMP_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .clr(clr), .lim(lim),
      .push(st_push[i]), .din(h_tx_data), .pop(st_pop[i]),
      .dout(st_dout[i]), .full(st_full[i]), .empty(st_empty[i]));
    msb_ring #(.DEPTH(MAXD), .W(SMP_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .clr(clr), .lim(lim),
      .push(sr_push[i]), .din(e_rx_data), .pop(sr_pop[i]),
      .dout(sr_dout[i]), .full(sr_full[i]), .empty(sr_empty[i]));
  end

  // ---------------- FIFOs behind the common path ----------------
  logic ftx_push, ftx_pop, ftx_full, ftx_empty;
  logic frx_push, frx_pop, frx_full, frx_empty;
  logic [SMP_W-1:0] ftx_dout, frx_dout;

  msb_ring #(.DEPTH(FIFO_D), .W(SMP_W)) u_ftx (
    .clk(clk), .rst_n(rst_n), .clr(clr), .lim(FLIM_W'(FIFO_D)),
    .push(ftx_push), .din(h_tx_data), .pop(ftx_pop),
    .dout(ftx_dout), .full(ftx_full), .empty(ftx_empty));
  msb_ring #(.DEPTH(FIFO_D), .W(SMP_W)) u_frx (
    .clk(clk), .rst_n(rst_n), .clr(clr), .lim(FLIM_W'(FIFO_D)),
    .push(frx_push), .din(e_rx_data), .pop(frx_pop),
    .dout(frx_dout), .full(frx_full), .empty(frx_empty));

  // ---------------- host transmit side ----------------
  logic [SLOT_W-1:0] ht_slot;
  logic ht_wr, ht_ok, ht_drop;
  assign ht_slot = h_tx_common ? hptr_tx : h_tx_slot;
  assign ht_wr   = en && h_tx_wr && !(fm && !h_tx_common);
  assign ht_ok   = fm ? !ftx_full : (act[ht_slot] && !st_full[ht_slot]);
  assign ht_drop = ht_wr && !ht_ok;
  assign ftx_push = ht_wr && fm && ht_ok;
  assign adv_htx  = ht_wr && !fm && h_tx_common;

  // ---------------- host receive side ----------------
  logic [SLOT_W-1:0] hr_slot;
  logic hr_rd, hr_ok;
  logic [SMP_W-1:0] hr_sel;
  assign hr_slot = h_rx_common ? hptr_rx : h_rx_slot;
  assign hr_rd   = en && h_rx_rd && !(fm && !h_rx_common);
  assign hr_ok   = fm ? !frx_empty : (act[hr_slot] && !sr_empty[hr_slot]);
  assign hr_sel  = fm ? frx_dout : sr_dout[hr_slot];
  assign frx_pop = hr_rd && fm && hr_ok;
  assign adv_hrx = hr_rd && !fm && h_rx_common;

  // ---------------- engine streams ----------------
  assign e_tx_slot  = eptr_tx;
  assign e_tx_valid = en && (fm ? !ftx_empty : !st_empty[eptr_tx]);
  assign e_tx_data  = fm ? ftx_dout : st_dout[eptr_tx];
  assign tx_hs      = e_tx_valid && e_tx_ready;
  assign ftx_pop    = tx_hs && fm;

  assign e_rx_slot  = eptr_rx;
  assign e_rx_ready = en && (fm ? !frx_full : !sr_full[eptr_rx]);
  assign rx_hs      = e_rx_valid && e_rx_ready;
  assign frx_push   = rx_hs && fm;

  always_comb begin
    for (int i = 0; i < NSLOT; i++) begin
      st_push[i]     = ht_wr && !fm && ht_ok && (ht_slot == SLOT_W'(i));
      sr_pop[i]      = hr_rd && !fm && hr_ok && (hr_slot == SLOT_W'(i));
      st_pop[i]      = tx_hs && !fm && (eptr_tx == SLOT_W'(i));
      sr_push[i]     = rx_hs && !fm && (eptr_rx == SLOT_W'(i));
      tx_slot_rdy[i] = en && !fm && act[i] && !st_full[i];
      rx_slot_rdy[i] = en && !fm && act[i] && !sr_empty[i];
    end
  end

  assign txff_rdy = en && fm && !ftx_full;
  assign txff_emp = en && fm && ftx_empty;
  assign rxff_rdy = en && fm && !frx_empty;
  assign rxff_ful = en && fm && frx_full;

  // ---------------- read data and sticky flags ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_rx_data <= '0; tx_ovr <= 1'b0; rx_udr <= 1'b0;
    end else begin
      if (en && h_rx_rd) h_rx_data <= (hr_rd && hr_ok) ? hr_sel : '0;
      if (!en) begin
        tx_ovr <= 1'b0; rx_udr <= 1'b0;
      end else begin
        if (ht_drop)          tx_ovr <= 1'b1;
        if (hr_rd && !hr_ok)  rx_udr <= 1'b1;
      end
    end
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !en)
    (e_tx_valid && !e_tx_ready) |=> (e_tx_valid && $stable(e_tx_data) && $stable(e_tx_slot))); // R7
  AST_RX_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !en)
    (e_rx_ready && !e_rx_valid) |=> (e_rx_ready && $stable(e_rx_slot))); // R8
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n || !en)
    tx_ovr |=> tx_ovr); // R5
  AST_UDR_STICKY: assert property (@(posedge clk) disable iff (!rst_n || !en)
    rx_udr |=> rx_udr); // R6
  AST_UDR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_udr) |-> (h_rx_data == '0)); // R6
endmodule

// File: tb/msb_hold_buf_test.sv
`timescale 1ns/1ps
module msb_hold_buf_test;
  localparam int NS = 8;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, fifo_mode = 1'b0;
  logic [1:0] fmt = '0, wire_cfg = '0;
  logic [2:0] nch_code = '0;
  logic h_tx_wr = 1'b0, h_tx_common = 1'b0, h_rx_rd = 1'b0, h_rx_common = 1'b0;
  logic [2:0] h_tx_slot = '0, h_rx_slot = '0;
  logic [31:0] h_tx_data = '0, e_rx_data = '0;
  logic e_tx_ready = 1'b0, e_rx_valid = 1'b0;
  logic [31:0] h_rx_data, e_tx_data;
  logic e_tx_valid, e_rx_ready;
  logic [2:0] e_tx_slot, e_rx_slot;
  logic [NS-1:0] tx_slot_rdy, rx_slot_rdy;
  logic txff_rdy, txff_emp, rxff_rdy, rxff_ful, tx_ovr, rx_udr;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  msb_hold_buf uut (
    .clk(clk), .rst_n(rst_n), .en(en), .fifo_mode(fifo_mode), .fmt(fmt),
    .wire_cfg(wire_cfg), .nch_code(nch_code),
    .h_tx_wr(h_tx_wr), .h_tx_common(h_tx_common), .h_tx_slot(h_tx_slot), .h_tx_data(h_tx_data),
    .h_rx_rd(h_rx_rd), .h_rx_common(h_rx_common), .h_rx_slot(h_rx_slot), .h_rx_data(h_rx_data),
    .e_tx_valid(e_tx_valid), .e_tx_ready(e_tx_ready), .e_tx_data(e_tx_data), .e_tx_slot(e_tx_slot),
    .e_rx_valid(e_rx_valid), .e_rx_ready(e_rx_ready), .e_rx_data(e_rx_data), .e_rx_slot(e_rx_slot),
    .tx_slot_rdy(tx_slot_rdy), .rx_slot_rdy(rx_slot_rdy),
    .txff_rdy(txff_rdy), .txff_emp(txff_emp), .rxff_rdy(rxff_rdy), .rxff_ful(rxff_ful),
    .tx_ovr(tx_ovr), .rx_udr(rx_udr));

  typedef struct packed {
    logic [1:0] f; logic [1:0] w; logic [2:0] n; logic [3:0] d; logic [3:0] a;
  } vec_t;
  localparam vec_t VEC [10] = '{
    '{2'd0, 2'd0, 3'd0, 4'd4, 4'd2}, '{2'd1, 2'd1, 3'd7, 4'd2, 4'd4},
    '{2'd0, 2'd2, 3'd0, 4'd1, 4'd8}, '{2'd1, 2'd3, 3'd0, 4'd1, 4'd8},
    '{2'd2, 2'd2, 3'd0, 4'd4, 4'd2}, '{2'd3, 2'd0, 3'd1, 4'd4, 4'd2},
    '{2'd2, 2'd1, 3'd2, 4'd2, 4'd4}, '{2'd3, 2'd0, 3'd3, 4'd2, 4'd4},
    '{2'd2, 2'd0, 3'd5, 4'd1, 4'd8}, '{2'd3, 2'd0, 3'd7, 4'd1, 4'd8}};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic setup(input logic [1:0] f, input logic [1:0] w, input logic [2:0] n, input logic fm);
    en = 1'b0; fmt = f; wire_cfg = w; nch_code = n; fifo_mode = fm;
    step(); en = 1'b1; step();
  endtask

  task automatic hwr(input logic com, input logic [2:0] s, input logic [31:0] d);
    h_tx_wr = 1'b1; h_tx_common = com; h_tx_slot = s; h_tx_data = d;
    step(); h_tx_wr = 1'b0;
  endtask

  task automatic hrd(input logic com, input logic [2:0] s);
    h_rx_rd = 1'b1; h_rx_common = com; h_rx_slot = s;
    step(); h_rx_rd = 1'b0;
  endtask

  task automatic epull(input string tag, input logic [2:0] s, input logic [31:0] d);
    chk({tag, " tx valid"}, 32'(e_tx_valid), 32'd1);
    chk({tag, " tx slot"}, 32'(e_tx_slot), 32'(s));
    chk({tag, " tx data"}, e_tx_data, d);
    e_tx_ready = 1'b1; step(); e_tx_ready = 1'b0;
  endtask

  task automatic epush(input string tag, input logic [2:0] s, input logic [31:0] d);
    chk({tag, " rx ready"}, 32'(e_rx_ready), 32'd1);
    chk({tag, " rx slot"}, 32'(e_rx_slot), 32'(s));
    e_rx_valid = 1'b1; e_rx_data = d; step(); e_rx_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1; step();
    // R12 reset state
    chk("R12 tx_slot_rdy", 32'(tx_slot_rdy), 32'd0);
    chk("R12 rx_slot_rdy", 32'(rx_slot_rdy), 32'd0);
    chk("R12 tx_valid", 32'(e_tx_valid), 32'd0);
    chk("R12 rx_ready", 32'(e_rx_ready), 32'd0);
    chk("R12 fifo flags", {28'd0, txff_rdy, txff_emp, rxff_rdy, rxff_ful}, 32'd0);
    chk("R12 sticky", {30'd0, tx_ovr, rx_udr}, 32'd0);
    chk("R12 rx data", h_rx_data, 32'd0);

    // R1 / R2 depth decode table
    for (int v = 0; v < 10; v++) begin
      string tg;
      tg = (VEC[v].f < 2) ? "R1" : "R2";
      setup(VEC[v].f, VEC[v].w, VEC[v].n, 1'b0);
      chk({tg, " active slots"}, 32'($countones(tx_slot_rdy)), 32'(VEC[v].a));
      for (int k = 0; k < int'(VEC[v].d) - 1; k++) hwr(1'b0, 3'd0, 32'(k));
      chk({tg, " slot0 room before last"}, 32'(tx_slot_rdy[0]), 32'd1);
      hwr(1'b0, 3'd0, 32'hFF);
      chk({tg, " slot0 full at depth"}, 32'(tx_slot_rdy[0]), 32'd0);
      chk({tg, " no overrun at depth"}, 32'(tx_ovr), 32'd0);
    end

    // R4 / R7 common transmit rotation with wrap (4 slots, depth 2)
    setup(2'd0, 2'd1, 3'd0, 1'b0);
    chk("R10 flags off outside fifo mode", {28'd0, txff_rdy, txff_emp, rxff_rdy, rxff_ful}, 32'd0);
    for (int k = 0; k < 5; k++) hwr(1'b1, 3'd0, 32'hA0 + 32'(k));
    epull("R4", 3'd0, 32'hA0);
    epull("R4", 3'd1, 32'hA1);
    epull("R7", 3'd2, 32'hA2);
    epull("R7", 3'd3, 32'hA3);
    epull("R4 wrap", 3'd0, 32'hA4);
    chk("R7 waits on empty slot", 32'(e_tx_valid), 32'd0);

    // R5 dedicated write, overrun
    hwr(1'b0, 3'd1, 32'hB1);
    hwr(1'b0, 3'd1, 32'hB2);
    chk("R5 no overrun yet", 32'(tx_ovr), 32'd0);
    hwr(1'b0, 3'd1, 32'hB3);
    chk("R5 overrun set", 32'(tx_ovr), 32'd1);
    chk("R5 slot1 full", 32'(tx_slot_rdy[1]), 32'd0);
    epull("R5", 3'd1, 32'hB1);
    chk("R7 slot after pull", 32'(e_tx_slot), 32'd2);
    chk("R5 overrun sticky", 32'(tx_ovr), 32'd1);

    // R8 / R6 receive path
    epush("R8", 3'd0, 32'hC0);
    epush("R8", 3'd1, 32'hC1);
    epush("R8", 3'd2, 32'hC2);
    epush("R8", 3'd3, 32'hC3);
    chk("R8 rx slot wrap", 32'(e_rx_slot), 32'd0);
    chk("R8 rx_slot_rdy", 32'(rx_slot_rdy), 32'h0F);
    hrd(1'b1, 3'd0);
    chk("R4 common read 0", h_rx_data, 32'hC0);
    hrd(1'b1, 3'd0);
    chk("R4 common read 1", h_rx_data, 32'hC1);
    hrd(1'b0, 3'd3);
    chk("R6 dedicated read", h_rx_data, 32'hC3);
    chk("R6 no underrun yet", 32'(rx_udr), 32'd0);
    hrd(1'b0, 3'd3);
    chk("R6 empty read zero", h_rx_data, 32'd0);
    chk("R6 underrun set", 32'(rx_udr), 32'd1);

    // R11 configuration frozen while enabled, cleared by disable
    wire_cfg = 2'd2; step();
    chk("R11 config change ignored", 32'($countones(tx_slot_rdy)), 32'd4);
    en = 1'b0; step(); en = 1'b1; step();
    chk("R11 new depth after re-enable", 32'($countones(tx_slot_rdy)), 32'd8);
    chk("R11 stores cleared", 32'(e_tx_valid), 32'd0);
    chk("R11 sticky cleared", {30'd0, tx_ovr, rx_udr}, 32'd0);

    // R3 inactive slots (2 active)
    setup(2'd0, 2'd0, 3'd0, 1'b0);
    hwr(1'b0, 3'd5, 32'hD5);
    chk("R3 inactive write drops", 32'(tx_ovr), 32'd1);
    hrd(1'b0, 3'd4);
    chk("R3 inactive read zero", h_rx_data, 32'd0);
    chk("R3 inactive read underrun", 32'(rx_udr), 32'd1);

    // R9 / R10 FIFO mode (TDM, 8 slots)
    setup(2'd2, 2'd0, 3'd6, 1'b1);
    chk("R9 slot flags off", {24'd0, tx_slot_rdy} | {24'd0, rx_slot_rdy}, 32'd0);
    chk("R10 empty fifo flags", {28'd0, txff_rdy, txff_emp, rxff_rdy, rxff_ful}, 32'hC);
    hwr(1'b0, 3'd0, 32'hEE);
    chk("R9 dedicated write ignored", {29'd0, txff_emp, e_tx_valid, tx_ovr}, 32'h4);
    for (int k = 0; k < 7; k++) hwr(1'b1, 3'd0, 32'hD0 + 32'(k));
    chk("R10 txff_rdy at 7", 32'(txff_rdy), 32'd1);
    hwr(1'b1, 3'd0, 32'hD7);
    chk("R10 tx fifo full", {30'd0, txff_rdy, txff_emp}, 32'd0);
    hwr(1'b1, 3'd0, 32'hD8);
    chk("R9 fifo overrun", 32'(tx_ovr), 32'd1);
    epull("R9", 3'd0, 32'hD0);
    epull("R9", 3'd1, 32'hD1);
    epull("R9", 3'd2, 32'hD2);
    for (int k = 0; k < 8; k++) epush("R9", 3'(k), 32'hE0 + 32'(k));
    chk("R10 rx fifo full", {30'd0, rxff_rdy, rxff_ful}, 32'h3);
    chk("R10 rx ready low when full", 32'(e_rx_ready), 32'd0);
    hrd(1'b0, 3'd0);
    chk("R9 dedicated read zero", h_rx_data, 32'd0);
    chk("R9 dedicated read no effect", {30'd0, rxff_ful, rx_udr}, 32'h2);
    hrd(1'b1, 3'd0);
    chk("R9 fifo read order", h_rx_data, 32'hE0);
    chk("R10 rx fifo not full", 32'(rxff_ful), 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule